// File: doc/BRIEF.md
# Fixed-Point Vertex Transform Pipeline

This block multiplies a stream of vertices by a constant 3x4 matrix of signed 16-bit fixed-point coefficients. Each vertex arrives as one 64-bit word of four signed 16-bit elements (x, y, z, w). For each vertex the block returns three transformed 16-bit coordinates, packed into two 32-bit output words. The fourth matrix column adds a translation term when w carries the fixed-point unit value.

Software first writes the twelve coefficients through a small write port while the block is idle. It then pulses a start strobe together with a vertex count. Vertices enter over a valid/ready handshake and results leave over another valid/ready handshake. A one-cycle done pulse closes the batch.

Inside, a single row multiplier takes one matrix row per cycle. The three rows of a vertex are issued on consecutive cycles into a three-stage pipeline:

1. Four products.
2. Two pair sums.
3. Total, shift and truncate.

This hides the multiplier latency, so a new vertex can be accepted every three cycles. Output backpressure stalls the whole pipeline.

Top module: `vertex_xform`

## Requirements
- R1: Each coordinate i (row i = 0..2) is formed as follows:
  - Take the wrapping signed 32-bit sum over j = 0..3 of coefficient(i,j) times element j of the vertex. Element j sits in input bits 16j+15:16j.
  - Shift that sum arithmetically right by 13.
  - Keep its low 16 bits, with wraparound and no saturation.
- R2: For each vertex, the first output word carries coordinate 0 in bits 15:0 and coordinate 1 in bits 31:16.
- R3: For each vertex, the second output word carries coordinate 2 in bits 15:0, and its bits 31:16 are zero.
- R4: Output order is fixed. For every vertex the first word is followed by the second word, and vertices leave in the order they were accepted.
- R5: While outValid is high and outReady is low, outValid stays high and outData holds its value on the next cycle. No result is lost or repeated.
- R6: After reset and while idle, inReady is low. A batch started with count N accepts exactly N vertices, and inReady stays low once N have been accepted.
- R7: donePulse is high for one cycle. That cycle is the one right after the cycle in which the second word of the last vertex of the batch was accepted.
- R8: A start with count zero accepts no vertex and raises donePulse on the cycle after the start.
- R9: Coefficient addressing and retention work as follows:
  - A write to cfgAddr = 4*row + column (rows 0..2) sets that coefficient.
  - Addresses 12..15 are ignored.
  - Writes while a batch is busy are ignored.
  - Coefficients reset to zero and persist across batches.
- R10: A start pulse while a batch is busy is ignored; the running batch keeps its original count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWrEn | input | 1 | Coefficient write strobe |
| cfgAddr | input | 4 | Coefficient index, 4*row + column |
| cfgData | input | 16 | Signed coefficient value |
| startPulse | input | 1 | Starts a batch when idle |
| vtxCount | input | 16 | Vertex count for the batch |
| donePulse | output | 1 | One-cycle batch completion pulse |
| inValid | input | 1 | Input vertex valid |
| inReady | output | 1 | Block accepts a vertex this cycle |
| inData | input | 64 | Four signed 16-bit elements, element 0 in bits 15:0 |
| outValid | output | 1 | Output word valid |
| outReady | input | 1 | Consumer accepts the output word |
| outData | output | 32 | Packed result word |

## Verification
The bench targets the following corner cases:

- **Extreme operands.** Full-range coefficients and vertices (including -32768) wrap the 32-bit sum. A design that saturated, shifted by the wrong amount or dropped the translation column would return wrong coordinates.
- **Random backpressure and input gaps.** These land stalls while a third-row result is waiting in the final stage. A design that advanced its pipeline anyway would overwrite or skip a vertex, or change a stalled word.
- **Mid-batch writes.** Coefficient writes and a second start pulse are issued in the middle of a batch, and a write is sent to an unused address. A design that honoured any of them would corrupt the following batch or hang on a wrong count.
- **Zero-count batch.** A batch of zero vertices checks that done comes one cycle later and that no vertex is taken.

// File: rtl/vxf_pkg.sv
package vxf_pkg;

  // Matrix geometry is fixed by the output packing: three rows, four lanes.
  localparam int ROWS  = 3;
  localparam int LANES = 4;
  localparam int PAIRS = LANES / 2;
  localparam int ADDR_W = $clog2(ROWS * LANES);

  // Strobes from control to datapath.
  typedef struct packed {
    logic       cfgOpen;   // coefficient writes permitted
    logic       loadVtx;   // capture the accepted vertex
    logic       issue;     // a row enters the multiplier this cycle
    logic [1:0] issueRow;  // which row is being issued
    logic       adv;       // pipeline registers advance
    logic       loadOut;   // capture a packed result pair
    logic       wordSel;   // 0: first output word, 1: second
  } vxfStrobes_t;

endpackage

// File: rtl/vxf_ctrl.sv
module vxf_ctrl
  import vxf_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic [CNT_W-1:0] vtxCount,
  input  logic             inValid,
  output logic             inReady,
  output logic             outValid,
  input  logic             outReady,
  input  logic             s3Row2,
  output logic             donePulse,
  output vxfStrobes_t      strb
);

  logic             busy;
  logic [CNT_W-1:0] inLeft;
  logic [CNT_W-1:0] outLeft;
  logic             holding;
  logic [1:0]       rowCnt;
  logic             bufValid;
  logic             wordSel;
  logic             doneQ;

  logic free, adv, issue, lastRow, accept, loadOut, outFire, lastPair, startIdle;

  always_comb begin
    free      = !bufValid || (outReady && wordSel);
    adv       = !s3Row2 || free;
    issue     = holding && adv;
    lastRow   = (rowCnt == 2'd2);
    inReady   = busy && (inLeft != '0) && (!holding || (issue && lastRow));
    accept    = inValid && inReady;
    loadOut   = s3Row2 && adv;
    outFire   = bufValid && outReady;
    lastPair  = outFire && wordSel && (outLeft == CNT_W'(1));
    startIdle = startPulse && !busy;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      inLeft  <= '0;
      outLeft <= '0;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= lastPair || (startIdle && (vtxCount == '0));
      if (startIdle && (vtxCount != '0)) begin
        busy    <= 1'b1;
        inLeft  <= vtxCount;
        outLeft <= vtxCount;
      end else begin
        if (accept) inLeft <= inLeft - CNT_W'(1);
        if (outFire && wordSel) outLeft <= outLeft - CNT_W'(1);
        if (lastPair) busy <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holding <= 1'b0;
      rowCnt  <= 2'd0;
    end else if (accept) begin
      holding <= 1'b1;
      rowCnt  <= 2'd0;
    end else if (issue) begin
      if (lastRow) holding <= 1'b0;
      else         rowCnt  <= rowCnt + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufValid <= 1'b0;
      wordSel  <= 1'b0;
    end else if (loadOut) begin
      bufValid <= 1'b1;
      wordSel  <= 1'b0;
    end else if (outFire) begin
      if (wordSel) begin
        bufValid <= 1'b0;
        wordSel  <= 1'b0;
      end else begin
        wordSel <= 1'b1;
      end
    end
  end

  always_comb begin
    strb.cfgOpen  = !busy;
    strb.loadVtx  = accept;
    strb.issue    = issue;
    strb.issueRow = rowCnt;
    strb.adv      = adv;
    strb.loadOut  = loadOut;
    strb.wordSel  = wordSel;
  end

  assign outValid  = bufValid;
  assign donePulse = doneQ;

  // The second word always follows an accepted first word.
  assert_word1_follows_R4: assert property (@(posedge clk) disable iff (!rstN)
    (bufValid && outReady && !wordSel) |=> (outValid && wordSel));

  // Nothing is taken once the batch has no vertices left.
  assert_no_extra_accept_R6: assert property (@(posedge clk) disable iff (!rstN)
    (inLeft == '0) |-> !inReady);

  // Completion leaves the block idle.
  assert_idle_at_done_R7: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> !busy);

  // An empty batch completes on the next cycle.
  assert_zero_count_R8: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse && !busy && (vtxCount == '0)) |=> donePulse);

endmodule

// File: rtl/vxf_datapath.sv
module vxf_datapath
  import vxf_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int FRAC_SHIFT = 13
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  vxfStrobes_t               strb,
  input  logic                      cfgWrEn,
  input  logic [ADDR_W-1:0]         cfgAddr,
  input  logic [DATA_W-1:0]         cfgData,
  input  logic [LANES*DATA_W-1:0]   inData,
  output logic [2*DATA_W-1:0]       outData,
  output logic                      s3Row2
);

  localparam int ACC_W = 2 * DATA_W;

  logic signed [DATA_W-1:0] coef [ROWS][LANES];
  logic [ROWS*LANES*DATA_W-1:0] coefFlat;
  logic [LANES*DATA_W-1:0] vtxReg;

  // Coefficient registers: written only while idle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < LANES; c++)
          coef[r][c] <= '0;
    end else if (strb.cfgOpen && cfgWrEn) begin
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < LANES; c++)
          if (cfgAddr == ADDR_W'(r * LANES + c)) coef[r][c] <= cfgData;
    end
  end

  always_comb begin
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < LANES; c++)
        coefFlat[(r*LANES+c)*DATA_W +: DATA_W] = coef[r][c];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             vtxReg <= '0;
    else if (strb.loadVtx) vtxReg <= inData;
  end

  // Issue: select the row and form four products.
  logic signed [DATA_W-1:0] selCoef [LANES];
  logic signed [ACC_W-1:0]  opA [LANES];
  logic signed [ACC_W-1:0]  opB [LANES];
  logic signed [ACC_W-1:0]  prodNext [LANES];

  always_comb begin
    for (int j = 0; j < LANES; j++) begin
      selCoef[j] = coef[0][j];
      for (int r = 1; r < ROWS; r++)
        if (strb.issueRow == 2'(r)) selCoef[j] = coef[r][j];
      opA[j]      = ACC_W'(selCoef[j]);
      opB[j]      = ACC_W'($signed(vtxReg[j*DATA_W +: DATA_W]));
      prodNext[j] = opA[j] * opB[j];
    end
  end

  // Stage 1: products.
  logic                    s1Valid;
  logic [1:0]              s1Row;
  logic signed [ACC_W-1:0] s1Prod [LANES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s1Row   <= 2'd0;
      for (int j = 0; j < LANES; j++) s1Prod[j] <= '0;
    end else if (strb.adv) begin
      s1Valid <= strb.issue;
      s1Row   <= strb.issueRow;
      for (int j = 0; j < LANES; j++) s1Prod[j] <= prodNext[j];
    end
  end

  // Stage 2: pair sums.
  logic                    s2Valid;
  logic [1:0]              s2Row;
  logic signed [ACC_W-1:0] s2Pair [PAIRS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s2Valid <= 1'b0;
      s2Row   <= 2'd0;
      for (int k = 0; k < PAIRS; k++) s2Pair[k] <= '0;
    end else if (strb.adv) begin
      s2Valid <= s1Valid;
      s2Row   <= s1Row;
      for (int k = 0; k < PAIRS; k++) s2Pair[k] <= s1Prod[2*k] + s1Prod[2*k+1];
    end
  end

  // Stage 3: row total, scale and truncate.
  function automatic logic [DATA_W-1:0] scaleTotal(input logic signed [ACC_W-1:0] p [PAIRS]);
    logic signed [ACC_W-1:0] acc;
    acc = '0;
    for (int k = 0; k < PAIRS; k++) acc = acc + p[k];
    return DATA_W'(acc >>> FRAC_SHIFT);
  endfunction

  logic              s3Valid;
  logic [1:0]        s3Row;
  logic [DATA_W-1:0] s3Coord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s3Valid <= 1'b0;
      s3Row   <= 2'd0;
      s3Coord <= '0;
    end else if (strb.adv) begin
      s3Valid <= s2Valid;
      s3Row   <= s2Row;
      s3Coord <= scaleTotal(s2Pair);
    end
  end

  assign s3Row2 = s3Valid && (s3Row == 2'd2);

  // Collector and output pair.
  logic [DATA_W-1:0]   coord0, coord1;
  logic [2*DATA_W-1:0] word0, word1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coord0 <= '0;
      coord1 <= '0;
    end else if (strb.adv && s3Valid) begin
      if (s3Row == 2'd0) coord0 <= s3Coord;
      if (s3Row == 2'd1) coord1 <= s3Coord;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      word0 <= '0;
      word1 <= '0;
    end else if (strb.loadOut) begin
      word0 <= {coord1, coord0};
      word1 <= {{DATA_W{1'b0}}, s3Coord};
    end
  end

  assign outData = strb.wordSel ? word1 : word0;

  // Second word never carries anything in its upper half.
  assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.wordSel |-> (outData[2*DATA_W-1:DATA_W] == '0));

  // Coefficients cannot move while a batch runs.
  assert_coef_frozen_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.cfgOpen |=> $stable(coefFlat));

endmodule

// File: rtl/vertex_xform.sv
module vertex_xform
  import vxf_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int FRAC_SHIFT = 13,
  parameter int CNT_W      = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cfgWrEn,
  input  logic [ADDR_W-1:0]       cfgAddr,
  input  logic [DATA_W-1:0]       cfgData,
  input  logic                    startPulse,
  input  logic [CNT_W-1:0]        vtxCount,
  output logic                    donePulse,
  input  logic                    inValid,
  output logic                    inReady,
  input  logic [LANES*DATA_W-1:0] inData,
  output logic                    outValid,
  input  logic                    outReady,
  output logic [2*DATA_W-1:0]     outData
);

  vxfStrobes_t strb;
  logic        s3Row2;

  vxf_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startPulse(startPulse),
    .vtxCount  (vtxCount),
    .inValid   (inValid),
    .inReady   (inReady),
    .outValid  (outValid),
    .outReady  (outReady),
    .s3Row2    (s3Row2),
    .donePulse (donePulse),
    .strb      (strb)
  );

  vxf_datapath #(.DATA_W(DATA_W), .FRAC_SHIFT(FRAC_SHIFT)) u_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .cfgWrEn(cfgWrEn),
    .cfgAddr(cfgAddr),
    .cfgData(cfgData),
    .inData (inData),
    .outData(outData),
    .s3Row2 (s3Row2)
  );

  // A stalled word is held unchanged.
  assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

endmodule

// File: tb/vertex_xform_bench.sv
module vertex_xform_bench;

  logic        clk;
  logic        rstN;
  logic        cfgWrEn;
  logic [3:0]  cfgAddr;
  logic [15:0] cfgData;
  logic        startPulse;
  logic [15:0] vtxCount;
  logic        donePulse;
  logic        inValid;
  logic        inReady;
  logic [63:0] inData;
  logic        outValid;
  logic        outReady;
  logic [31:0] outData;

  vertex_xform u_vertex_xform (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .startPulse(startPulse), .vtxCount(vtxCount), .donePulse(donePulse),
    .inValid(inValid), .inReady(inReady), .inData(inData),
    .outValid(outValid), .outReady(outReady), .outData(outData)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int nChecks = 0;
  int nErrors = 0;
  int cycles = 0;
  int doneCnt = 0;
  int readyMode = 0;

  // Reference model state.
  logic signed [15:0] mc [3][4];
  logic [31:0] expQ [$];
  bit   mBusy = 0;
  int   mRemIn = 0;
  int   mRemOut = 0;
  bit   expDone = 0;
  bit   mWord = 0;
  bit   prevStall = 0;
  logic [31:0] prevData = '0;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  function automatic logic [15:0] refCoord(int row, logic [63:0] v);
    logic signed [31:0] acc;
    acc = 0;
    for (int j = 0; j < 4; j++)
      acc = acc + 32'(mc[row][j]) * 32'($signed(v[j*16 +: 16]));
    return 16'(acc >>> 13);
  endfunction

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  endtask

  // Monitor: sampled 1 ns before each rising edge.
  always begin
    bit busyNow;
    logic [31:0] e;
    @(negedge clk);
    #3;
    cycles++;
    if (cycles > 150000) begin
      chk(0, "watchdog", 32'(cycles), 32'd0);
      finishRun();
    end
    if (rstN) begin
      busyNow = mBusy;
      // R7 / R8: done timing
      if (donePulse || expDone) chk(donePulse == expDone, "R7 R8 donePulse", 32'(donePulse), 32'(expDone));
      if (donePulse) doneCnt++;
      expDone = 0;
      // R5: stalled word held
      if (prevStall) chk(outValid && outData == prevData, "R5 stall hold", outData, prevData);
      prevStall = outValid && !outReady;
      prevData  = outData;
      // R6: no acceptance past the count
      if (inValid && mRemIn == 0) chk(!inReady, "R6 inReady with nothing left", 32'(inReady), 32'd0);
      if (inValid && inReady && mRemIn > 0) begin
        mRemIn--;
        expQ.push_back({refCoord(1, inData), refCoord(0, inData)});
        expQ.push_back({16'h0000, refCoord(2, inData)});
      end
      if (outValid && outReady) begin
        if (expQ.size() == 0) chk(0, "R4 unexpected word", outData, 32'd0);
        else begin
          e = expQ.pop_front();
          chk(outData == e, mWord ? "R1 R3 R4 second word" : "R1 R2 R4 first word", outData, e);
          if (mWord) begin
            mRemOut--;
            if (mRemOut == 0) begin mBusy = 0; expDone = 1; end
          end
          mWord = !mWord;
        end
      end
      // R9: coefficient writes only while idle, addresses 0..11
      if (cfgWrEn && !busyNow && cfgAddr < 12) mc[cfgAddr / 4][cfgAddr % 4] = cfgData;
      // R10: start honoured only while idle
      if (startPulse && !busyNow) begin
        if (vtxCount == 0) expDone = 1;
        else begin mBusy = 1; mRemIn = vtxCount; mRemOut = vtxCount; end
      end
    end
  end

  // Output consumer.
  initial begin
    outReady = 1'b0;
    forever begin
      @(posedge clk); #1;
      outReady = (readyMode == 0) ? 1'b1 : (($urandom % 100) < 55);
    end
  end

  task automatic cfgWrite(int addr, logic [15:0] val);
    @(posedge clk); #1;
    cfgWrEn = 1; cfgAddr = 4'(addr); cfgData = val;
    @(posedge clk); #1;
    cfgWrEn = 0;
  endtask

  task automatic startBatch(int n);
    @(posedge clk); #1;
    startPulse = 1; vtxCount = 16'(n);
    @(posedge clk); #1;
    startPulse = 0;
  endtask

  function automatic logic [63:0] mkVert(int range);
    logic [63:0] v;
    for (int j = 0; j < 4; j++) begin
      if (range == 0) v[j*16 +: 16] = 16'($urandom);
      else v[j*16 +: 16] = 16'(int'($urandom % (2*range + 1)) - range);
    end
    if (($urandom % 4) == 0) v[63:48] = 16'h8000;
    return v;
  endfunction

  task automatic sendVerts(int n, bit gaps, int range);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      if (gaps && ($urandom % 3) == 0) begin
        inValid = 0;
        @(posedge clk); #1;
      end
      inValid = 1;
      inData  = mkVert(range);
      while (1) begin
        @(negedge clk); #3;
        if (inReady) break;
        @(posedge clk); #1;
      end
    end
    @(posedge clk); #1;
    inValid = 0;
  endtask

  task automatic waitDone();
    int target;
    target = doneCnt + 1;
    while (doneCnt < target) @(posedge clk);
  endtask

  task automatic runBatch(int n, bit gaps, int range);
    startBatch(n);
    sendVerts(n, gaps, range);
    waitDone();
  endtask

  initial begin
    for (int r = 0; r < 3; r++) for (int c = 0; c < 4; c++) mc[r][c] = 0;
    rstN = 0; cfgWrEn = 0; cfgAddr = 0; cfgData = 0;
    startPulse = 0; vtxCount = 0; inValid = 0; inData = 0;
    repeat (5) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk); #3;
    // R6: reset state
    chk(!outValid && !inReady && !donePulse, "R6 reset state",
        {29'd0, outValid, inReady, donePulse}, 32'd0);

    // Identity with translation column, unit = 8192.
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < 4; c++)
        cfgWrite(r*4 + c, (c == r) ? 16'sd8192 : (c == 3 ? 16'(100*(r+1)) : 16'sd0));
    readyMode = 0;
    runBatch(4, 0, 4000);

    // Moderate random matrix, random gaps and backpressure.
    for (int a = 0; a < 12; a++) cfgWrite(a, 16'(int'($urandom % 16001) - 8000));
    readyMode = 1;
    fork
      runBatch(24, 1, 8000);
      begin
        repeat (12) @(posedge clk);
        cfgWrite(0, 16'h1234);   // R9: ignored while busy
        startBatch(5);           // R10: ignored while busy
      end
    join
    runBatch(6, 1, 8000);

    // Unused address ignored; full-range matrix and vertices (wrap).
    cfgWrite(13, 16'h7FFF);
    for (int a = 0; a < 12; a++) cfgWrite(a, (a % 3 == 0) ? 16'h8000 : 16'($urandom));
    runBatch(10, 1, 0);
    for (int a = 0; a < 12; a++) cfgWrite(a, 16'h7FFF);
    runBatch(4, 0, 0);

    // R8: zero-count batch, inValid held high.
    startBatch(0);
    inValid = 1; inData = 64'h1;
    repeat (5) @(posedge clk);
    #1 inValid = 0;

    // Back-to-back with an always-ready consumer.
    readyMode = 0;
    runBatch(10, 0, 0);

    repeat (20) @(posedge clk);
    chk(expQ.size() == 0, "R4 leftover expected words", 32'(expQ.size()), 32'd0);
    finishRun();
  end

endmodule